// File: doc/BRIEF.md
# Battery Full-Capacity Aging Estimator

This block holds the learned full-charge capacity of a battery pack. It lowers that value in fixed steps while no complete learning cycle occurs to refresh it. Two independent events cause a step. The first is every second increment of the charge-cycle counter. The second is cumulative self-discharge reaching about 1.56 % of design capacity without a charge to full in between. Each step removes 1/1024 of the design capacity. Aging runs only while an enable bit from a configuration byte is set.

The surrounding gauge supplies events as single-cycle strobes. These are cycle-count increments, self-discharge reductions with their amount, and full-charge events. It also supplies a load port, through which a newly learned capacity replaces the held value. The block tracks the parity of cycle-count increments and keeps the self-discharge accumulator, including its remainder. It presents the current full capacity together with one pulse for every aging step it applies.

Top module: `age_estimator`

## Requirements
- R1: While `age_en` is 0, `full_cap` changes only through a load, `age_pulse` never fires, and the cycle parity and self-discharge accumulator are held at zero.
- R2: Each aging step lowers `full_cap` by `design_cap >> 10`.
- R3: With aging enabled, one step is taken on every second `cyc_inc` strobe counted since reset, load or disable.
- R4: Each `sd_stb` adds `sd_amt` to an accumulator. When the sum reaches `design_cap >> 6`, one step is taken and the threshold is subtracted. The remainder is kept, clipped to one below the threshold.
- R5: A `full_evt` clears the accumulator. A same-cycle `sd_stb` is discarded.
- R6: `full_cap` saturates at 0 and never wraps.
- R7: When both triggers fire in one cycle, two steps are subtracted at once. `age_pulse` then fires on two consecutive cycles. Unissued pulses are queued, with saturation at 15.
- R8: `load_en` sets `full_cap` to `load_val`, suppresses any step of that cycle (no subtraction, no pulse) and clears the cycle parity. The accumulator still advances.
- R9: Synchronous active-high `rst` sets `full_cap` to `design_cap` and clears parity, accumulator, queue and pulse.
- R10: Outputs are registered. A step triggered by inputs at one clock edge shows on `full_cap` and `age_pulse` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| age_en | input | 1 | Aging enable from the configuration byte |
| design_cap | input | CAP_W | Fixed design capacity |
| cyc_inc | input | 1 | Cycle-count increment strobe |
| sd_stb | input | 1 | Self-discharge reduction strobe |
| sd_amt | input | CAP_W | Amount of the self-discharge reduction |
| full_evt | input | 1 | Battery charged to full |
| load_en | input | 1 | Load learned full capacity |
| load_val | input | CAP_W | Learned full capacity value |
| full_cap | output | CAP_W | Current full-capacity value |
| age_pulse | output | 1 | One pulse per aging step applied |

## Verification
A wrong cycle parity moves every later cycle-driven step by one strobe. This shows on `full_cap` at the next odd increment. A wrong accumulator remainder moves a self-discharge step earlier or later by one or more strobes, and the error persists until a full-charge event resets it. A lost queued pulse leaves `full_cap` lower than the pulse count implies, and this appears one cycle after a double trigger. Because the reference model is compared on every clock, each of these errors is reported on the first cycle the ports diverge.

// File: rtl/age_pkg.sv
package age_pkg;
    localparam int OWE_W   = 4;
    localparam int STEP_SH = 10;
    localparam int THR_SH  = 6;
    typedef logic [1:0] nstep_t;
    typedef logic [OWE_W-1:0] owe_t;
endpackage

// File: rtl/age_cycle_pair.sv
module age_cycle_pair (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic cyc_inc,
    output logic trig
);
    typedef struct packed {
        logic par;
    } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        trig = 1'b0;
        if (clr) begin
            st_d.par = 1'b0;
        end else if (cyc_inc) begin
            trig     = st_q.par;
            st_d.par = ~st_q.par;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/age_sd_accum.sv
module age_sd_accum #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             full_evt,
    input  logic             sd_stb,
    input  logic [CAP_W-1:0] sd_amt,
    input  logic [CAP_W-1:0] thr,
    output logic             trig
);
    localparam int SUM_W = CAP_W + 1;

    typedef struct packed {
        logic [CAP_W-1:0] acc;
    } st_t;
    st_t st_d, st_q;

    logic [SUM_W-1:0] sum, rem, thr_x, clip;

    always_comb begin
        st_d  = st_q;
        trig  = 1'b0;
        thr_x = {1'b0, thr};
        clip  = (thr == '0) ? '0 : thr_x - 1'b1;
        sum   = {1'b0, st_q.acc} + {1'b0, sd_amt};
        rem   = sum - thr_x;
        if (!en || full_evt) begin
            st_d.acc = '0;
        end else if (sd_stb) begin
            if (sum >= thr_x) begin
                trig = 1'b1;
                if (rem >= thr_x) st_d.acc = clip[CAP_W-1:0];
                else              st_d.acc = rem[CAP_W-1:0];
            end else begin
                st_d.acc = sum[CAP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/age_cap_reg.sv
module age_cap_reg #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CAP_W-1:0] design_cap,
    input  logic             load_en,
    input  logic [CAP_W-1:0] load_val,
    input  age_pkg::nstep_t  nsteps,
    input  logic [CAP_W-1:0] step,
    output logic [CAP_W-1:0] full_cap
);
    localparam int DEC_W = CAP_W + 1;

    typedef struct packed {
        logic [CAP_W-1:0] fcc;
    } st_t;
    st_t st_d, st_q;

    logic [DEC_W-1:0] dec, cur;

    always_comb begin
        st_d = st_q;
        cur  = {1'b0, st_q.fcc};
        case (nsteps)
            2'd1:    dec = {1'b0, step};
            2'd2:    dec = {step, 1'b0};
            default: dec = '0;
        endcase
        if (load_en)        st_d.fcc = load_val;
        else if (cur > dec) st_d.fcc = st_q.fcc - dec[CAP_W-1:0];
        else                st_d.fcc = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.fcc <= design_cap;
        else     st_q     <= st_d;
    end

    assign full_cap = st_q.fcc;
endmodule

// File: rtl/age_pulse_seq.sv
module age_pulse_seq (
    input  logic            clk,
    input  logic            rst,
    input  age_pkg::nstep_t nsteps,
    output logic            pulse
);
    import age_pkg::*;
    localparam int TOT_W = OWE_W + 1;
    localparam logic [TOT_W-1:0] OWE_MAX = TOT_W'((1 << OWE_W) - 1);

    typedef struct packed {
        owe_t owe;
        logic pls;
    } st_t;
    st_t st_d, st_q;

    logic [TOT_W-1:0] tot, left;

    always_comb begin
        st_d     = st_q;
        tot      = {1'b0, st_q.owe} + TOT_W'(nsteps);
        st_d.pls = (tot != '0);
        left     = tot - TOT_W'(st_d.pls);
        if (left > OWE_MAX) st_d.owe = OWE_MAX[OWE_W-1:0];
        else                st_d.owe = left[OWE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse = st_q.pls;
endmodule

// File: rtl/age_estimator.sv
module age_estimator #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             age_en,
    input  logic [CAP_W-1:0] design_cap,
    input  logic             cyc_inc,
    input  logic             sd_stb,
    input  logic [CAP_W-1:0] sd_amt,
    input  logic             full_evt,
    input  logic             load_en,
    input  logic [CAP_W-1:0] load_val,
    output logic [CAP_W-1:0] full_cap,
    output logic             age_pulse
);
    import age_pkg::*;

    logic [CAP_W-1:0] step, thr;
    logic             trig_c, trig_s, pair_clr;
    nstep_t           nsteps;

    assign step     = design_cap >> STEP_SH;
    assign thr      = design_cap >> THR_SH;
    assign pair_clr = ~age_en | load_en;

    always_comb begin
        if (load_en) nsteps = 2'd0;
        else         nsteps = {1'b0, trig_c} + {1'b0, trig_s};
    end

    age_cycle_pair u_pair (
        .clk(clk), .rst(rst), .clr(pair_clr), .cyc_inc(cyc_inc), .trig(trig_c)
    );

    age_sd_accum #(.CAP_W(CAP_W)) u_sd (
        .clk(clk), .rst(rst), .en(age_en), .full_evt(full_evt),
        .sd_stb(sd_stb), .sd_amt(sd_amt), .thr(thr), .trig(trig_s)
    );

    age_cap_reg #(.CAP_W(CAP_W)) u_cap (
        .clk(clk), .rst(rst), .design_cap(design_cap), .load_en(load_en),
        .load_val(load_val), .nsteps(nsteps), .step(step), .full_cap(full_cap)
    );

    age_pulse_seq u_pls (
        .clk(clk), .rst(rst), .nsteps(nsteps), .pulse(age_pulse)
    );
endmodule

// File: rtl/age_estimator_chk.sv
module age_estimator_chk #(
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             age_en,
    input logic [CAP_W-1:0] design_cap,
    input logic             load_en,
    input logic [CAP_W-1:0] load_val,
    input logic [CAP_W-1:0] full_cap,
    input logic             age_pulse
);
    logic [CAP_W:0] max_drop;
    assign max_drop = {1'b0, design_cap >> 10} << 1;

    a_r9_reset_value: assert property (@(posedge clk)
        $past(rst) |-> full_cap == design_cap);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> full_cap == $past(load_val));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> full_cap <= $past(full_cap));

    a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        (!age_en && !load_en) |=> full_cap == $past(full_cap));

    a_r2_drop_bounded: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ({1'b0, $past(full_cap)} - {1'b0, full_cap}) <= max_drop);
endmodule

bind age_estimator age_estimator_chk #(.CAP_W(CAP_W)) u_chk (
    .clk(clk), .rst(rst), .age_en(age_en), .design_cap(design_cap),
    .load_en(load_en), .load_val(load_val), .full_cap(full_cap),
    .age_pulse(age_pulse)
);

// File: tb/age_estimator_tb.sv
module age_estimator_tb;
    localparam int CAP_W = 16;
    localparam int DC    = 40960;

    logic clk = 1'b0;
    logic rst, age_en, cyc_inc, sd_stb, full_evt, load_en;
    logic [CAP_W-1:0] design_cap, sd_amt, load_val, full_cap;
    logic age_pulse;

    always #4 clk = ~clk;

    age_estimator #(.CAP_W(CAP_W)) u_dut (
        .clk(clk), .rst(rst), .age_en(age_en), .design_cap(design_cap),
        .cyc_inc(cyc_inc), .sd_stb(sd_stb), .sd_amt(sd_amt), .full_evt(full_evt),
        .load_en(load_en), .load_val(load_val), .full_cap(full_cap),
        .age_pulse(age_pulse)
    );

    int n_vec = 0, n_bad = 0;
    string tag = "R9";
    int m_fcc, m_acc, m_par, m_owe, m_pls;

    task automatic model();
        int tc = 0, ts = 0, n, s, r, d, tot;
        int step = DC / 1024, thr = DC / 64;
        if (rst) begin
            m_fcc = DC; m_acc = 0; m_par = 0; m_owe = 0; m_pls = 0;
            return;
        end
        if (!age_en) begin
            m_par = 0; m_acc = 0;
        end else begin
            if (cyc_inc) begin
                if (m_par == 1) begin tc = 1; m_par = 0; end
                else m_par = 1;
            end
            if (full_evt) m_acc = 0;
            else if (sd_stb) begin
                s = m_acc + int'(sd_amt);
                if (s >= thr) begin
                    ts = 1; r = s - thr;
                    if (r >= thr) r = (thr == 0) ? 0 : thr - 1;
                    m_acc = r;
                end else m_acc = s;
            end
        end
        if (load_en) begin
            m_par = 0; n = 0; m_fcc = int'(load_val);
        end else begin
            n = tc + ts; d = n * step;
            m_fcc = (m_fcc > d) ? m_fcc - d : 0;
        end
        tot = m_owe + n;
        m_pls = (tot > 0) ? 1 : 0;
        m_owe = tot - m_pls;
        if (m_owe > 15) m_owe = 15;
    endtask

    task automatic cyc(input logic r, input logic en, input logic ci, input logic ss,
                       input int amt, input logic fe, input logic ld, input int lv);
        rst = r; age_en = en; cyc_inc = ci; sd_stb = ss; sd_amt = CAP_W'(amt);
        full_evt = fe; load_en = ld; load_val = CAP_W'(lv);
        @(posedge clk);
        model();
        #1;
        n_vec++;
        if (int'(full_cap) != m_fcc || int'(age_pulse) != m_pls) begin
            n_bad++;
            $display("FAIL %s: full_cap=%0d pulse=%0d expected full_cap=%0d pulse=%0d",
                     tag, full_cap, age_pulse, m_fcc, m_pls);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, age_en, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        design_cap = CAP_W'(DC);
        age_en = 0;
        // R9: reset value
        tag = "R9";
        cyc(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 900, 0, 0, 0);
        // R1: disabled, strobes have no effect and leave no progress behind
        tag = "R1";
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, 1000, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        idle(2);
        // R3 / R2 / R10: every second cycle increment ages by 40
        tag = "R3";
        for (int i = 0; i < 5; i++) begin cyc(0, 1, 1, 0, 0, 0, 0, 0); idle(1); end
        tag = "R10";
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        // R4: accumulate 300 x3 -> one step at 900, remainder 260
        tag = "R4";
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, 300, 0, 0, 0);
        cyc(0, 1, 0, 1, 380, 0, 0, 0);
        cyc(0, 1, 0, 1, 5000, 0, 0, 0);
        cyc(0, 1, 0, 1, 1, 0, 0, 0);
        idle(2);
        // R5: full charge breaks the chain, same-cycle strobe lost
        tag = "R5";
        cyc(0, 1, 0, 1, 500, 0, 0, 0);
        cyc(0, 1, 0, 1, 500, 1, 0, 0);
        cyc(0, 1, 0, 1, 500, 0, 0, 0);
        cyc(0, 1, 0, 1, 100, 0, 0, 0);
        idle(2);
        // R7: both triggers in one cycle, two pulses back to back
        tag = "R7";
        cyc(0, 1, 0, 0, 0, 1, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 700, 0, 0, 0);
        idle(3);
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 1, 640, 0, 0, 0);
        idle(20);
        // R8: load overrides a same-cycle step and clears parity
        tag = "R8";
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 900, 0, 1, 30000);
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        idle(2);
        // R6: saturation at zero
        tag = "R6";
        cyc(0, 1, 0, 0, 0, 0, 1, 50);
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 640, 0, 0, 0);
        cyc(0, 1, 1, 1, 640, 0, 0, 0);
        idle(3);
        // mixed traffic
        tag = "R2";
        cyc(0, 1, 0, 0, 0, 0, 1, DC);
        for (int i = 0; i < 400; i++) begin
            int x = int'($urandom_range(0, 99));
            cyc(0, (x < 92), ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0),
                int'($urandom_range(0, 800)), (x < 3), (x > 97),
                int'($urandom_range(0, 65535)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule